// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

The block is one bank of 32 general-purpose lines. The lines form four ports of eight lines each. Software reaches the bank over a plain 32-bit register bus. The bus has a byte address, a write enable, write data and a combinational read-data return. Per line, software can choose:

- whether the line is an output (direction);
- the level the line drives when it is an output (output latch);
- a pin-select flag, which the bank passes out to the neighbouring logic.

Every input line passes through a two-stage synchroniser. A per-line 2-bit field then decides which edges are recorded: none, falling, rising or both. Each recorded edge sets a sticky status bit. Software clears a status bit by writing a one to it. A single interrupt output is high while any status bit is set.

The order of the four port bytes inside each bus word is fixed at build time. In normal order, the port holding lines 0 to 7 sits in the most significant byte. The 2-bit fields are grouped by port pairs with the pair swapped inside each mask word. In reversed order, line n is bit n, and its field starts at bit 2n of a 64-bit space made of the two mask words. All state is kept in line order inside the block. Only the bus view changes with the selected order.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every register reads 0, pinOe and pinOut are 0, and irqOut is low.
- R2: Word 0x00 holds the pin-select flags, word 0x08 the direction (1 = output) and word 0x0C the output latch. pinSel, pinOe and pinOut show these in line order from the cycle after the write.
- R3: A read of 0x0C returns the output latch for lines with direction 1. For lines with direction 0 it returns the synchronised pin level, which follows a pin change after two clock edges.
- R4: Each line has a 2-bit edge field: 0 none, 1 falling, 2 rising, 3 both. Lines 0 to 15 have their fields in word 0x14 and lines 16 to 31 in word 0x18. Both words read back as written.
- R5: Word 0x10 holds the sticky status bits. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged.
- R6: An edge that is recorded in the same cycle as a clear of its bit leaves the bit set.
- R7: A line with direction 1, or with an edge field of 0, never sets its status bit.
- R8: irqOut is high exactly when at least one status bit is set.
- R9: With the default normal order, line n uses 1-bit position 8*(3 - n/8) + n%8. Its edge field starts at position 2*(8*((n/8) xor 1) + n%8) of the 64-bit mask space. Positions 0 to 31 of that space are word 0x14 and positions 32 to 63 are word 0x18.
- R10: With reversed order, line n uses 1-bit position n, and its edge field starts at position 2n of the mask space.
- R11: Reads of 0x04 and 0x1C return 0, and writes to them change nothing.
- R12: A pin change applied before clock edge 1 sets its status bit, and raises irqOut, at edge 3 and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 5 | Byte address of the register word |
| busWe | input | 1 | Write enable, sampled at the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinIn | input | 32 | Pin levels, line order, asynchronous |
| pinOut | output | 32 | Output latch, line order |
| pinOe | output | 32 | Output enable (direction), line order |
| pinSel | output | 32 | Pin-select flags, line order |
| irqOut | output | 1 | Combined interrupt |

## Verification
The results of a register write show on the outputs and in read data after the clock edge that samples the write. A pin change shows in the data read after two edges and in the status and irqOut after three edges. The bench keeps a behavioural model with the same edge-by-edge timing and advances it on every rising edge. It compares every output two nanoseconds after that edge, while all inputs are held still. The directed checks for the three-edge latency and for the set-while-clearing case sample at the falling edge that follows each counted rising edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 4;
  localparam int LINES     = PORT_W * NUM_PORTS;
  localparam int DATA_W    = 32;
  localparam int MODE_W    = 2;

  typedef struct packed {
    logic wrSel;
    logic wrDir;
    logic wrData;
    logic wrStat;
    logic wrMaskLo;
    logic wrMaskHi;
  } bankStrb_t;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_SEL,
    RS_DIR,
    RS_DATA,
    RS_STAT,
    RS_MASK_LO,
    RS_MASK_HI
  } readSel_t;

  // bus bit that carries a line in the one-bit-per-line words
  function automatic int lineBitPos(int line, bit reversed);
    int port = line / PORT_W;
    int pin  = line % PORT_W;
    return reversed ? line : PORT_W * (NUM_PORTS - 1 - port) + pin;
  endfunction

  // start of a line's edge field in the 64-bit mask space
  function automatic int lineMaskPos(int line, bit reversed);
    int port = line / PORT_W;
    int pin  = line % PORT_W;
    return reversed ? MODE_W * line : MODE_W * (PORT_W * (port ^ 1) + pin);
  endfunction

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output bankStrb_t         strb,
  output readSel_t          rdSel
);

  localparam int WORD_LSB = 2;

  logic [ADDR_W-WORD_LSB-1:0] wordIdx;
  assign wordIdx = busAddr[ADDR_W-1:WORD_LSB];

  always_comb begin
    strb  = '0;
    rdSel = RS_ZERO;
    case (wordIdx)
      3'd0: begin rdSel = RS_SEL;     strb.wrSel    = busWe; end
      3'd2: begin rdSel = RS_DIR;     strb.wrDir    = busWe; end
      3'd3: begin rdSel = RS_DATA;    strb.wrData   = busWe; end
      3'd4: begin rdSel = RS_STAT;    strb.wrStat   = busWe; end
      3'd5: begin rdSel = RS_MASK_LO; strb.wrMaskLo = busWe; end
      3'd6: begin rdSel = RS_MASK_HI; strb.wrMaskHi = busWe; end
      default: ;
    endcase
  end

  // R11: unmapped words never raise a write strobe
  always_comb begin
    if (rdSel == RS_ZERO) begin
      p_reserved_quiet_r11: assert (strb == '0);
    end
  end

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter bit REVERSED_PORTS = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrb_t         strb,
  input  readSel_t          rdSel,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  output logic [LINES-1:0]  pinSel,
  output logic              irqOut
);

  logic [LINES-1:0] selQ, dirQ, outQ, statQ;
  logic [LINES-1:0] sync1Q, sync2Q, prevQ;
  logic [LINES-1:0][MODE_W-1:0] modeQ;

  logic [LINES-1:0] wrLines, dataView, riseV, fallV, hitV, clrV, quietV;
  logic [LINES-1:0][MODE_W-1:0] modeWd;
  logic [LINES-1:0] modeWe;

  wire [DATA_W-1:0] selBus, dirBus, dataBus, statBus, maskLoBus, maskHiBus;

  assign dataView = (dirQ & outQ) | (~dirQ & sync2Q);
  assign riseV    = sync2Q & ~prevQ;
  assign fallV    = ~sync2Q & prevQ;
  assign clrV     = strb.wrStat ? wrLines : '0;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    localparam int BP = lineBitPos(l, REVERSED_PORTS);
    localparam int MP = lineMaskPos(l, REVERSED_PORTS);

    assign wrLines[l] = busWdata[BP];
    assign selBus[BP]  = selQ[l];
    assign dirBus[BP]  = dirQ[l];
    assign dataBus[BP] = dataView[l];
    assign statBus[BP] = statQ[l];

    assign hitV[l]   = ~dirQ[l] & ((modeQ[l][1] & riseV[l]) | (modeQ[l][0] & fallV[l]));
    assign quietV[l] = dirQ[l] | (modeQ[l] == '0);

    if (MP < DATA_W) begin : g_lo
      assign maskLoBus[MP +: MODE_W] = modeQ[l];
      assign modeWd[l] = busWdata[MP +: MODE_W];
      assign modeWe[l] = strb.wrMaskLo;
    end else begin : g_hi
      assign maskHiBus[MP-DATA_W +: MODE_W] = modeQ[l];
      assign modeWd[l] = busWdata[MP-DATA_W +: MODE_W];
      assign modeWe[l] = strb.wrMaskHi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= '0;
      dirQ   <= '0;
      outQ   <= '0;
      statQ  <= '0;
      sync1Q <= '0;
      sync2Q <= '0;
      prevQ  <= '0;
      modeQ  <= '0;
    end else begin
      sync1Q <= pinIn;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q;
      statQ  <= (statQ & ~clrV) | hitV;
      if (strb.wrSel)  selQ <= wrLines;
      if (strb.wrDir)  dirQ <= wrLines;
      if (strb.wrData) outQ <= wrLines;
      for (int l = 0; l < LINES; l++) begin
        if (modeWe[l]) modeQ[l] <= modeWd[l];
      end
    end
  end

  always_comb begin
    case (rdSel)
      RS_SEL:     busRdata = selBus;
      RS_DIR:     busRdata = dirBus;
      RS_DATA:    busRdata = dataBus;
      RS_STAT:    busRdata = statBus;
      RS_MASK_LO: busRdata = maskLoBus;
      RS_MASK_HI: busRdata = maskHiBus;
      default:    busRdata = '0;
    endcase
  end

  assign pinOut = outQ;
  assign pinOe  = dirQ;
  assign pinSel = selQ;
  assign irqOut = |statQ;

  // R5: a written one clears the bit unless a new edge lands on it
  p_w1c_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStat |=> ((statQ & $past(clrV & ~hitV)) == '0));

  // R5: without a status write, set bits stay set
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStat |=> ((statQ & $past(statQ)) == $past(statQ)));

  // R6: a recorded edge always ends up set, clear or not
  p_edge_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hitV != '0) |=> ((statQ & $past(hitV)) == $past(hitV)));

  // R7: outputs and disabled lines never gain a status bit
  p_quiet_lines_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((statQ & ~$past(statQ) & $past(quietV)) == '0));

  // R2: direction only moves on its own write
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(pinOe));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter bit REVERSED_PORTS = 1'b0,
  parameter int ADDR_W         = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  output logic [LINES-1:0]  pinSel,
  output logic              irqOut
);

  bankStrb_t strb;
  readSel_t  rdSel;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strb   (strb),
    .rdSel  (rdSel)
  );

  gpio_bank_datapath #(.REVERSED_PORTS(REVERSED_PORTS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdSel   (rdSel),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .pinSel  (pinSel),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/gpio_edge_bank_test.sv
`timescale 1ns/1ps
module gpio_edge_bank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] pinIn = '0;

  logic [31:0] rd [2];
  logic [31:0] pOut [2];
  logic [31:0] pOe [2];
  logic [31:0] pSel [2];
  logic        irq [2];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_edge_bank #(.REVERSED_PORTS(1'b0)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(rd[0]), .pinIn(pinIn), .pinOut(pOut[0]), .pinOe(pOe[0]),
    .pinSel(pSel[0]), .irqOut(irq[0]));

  gpio_edge_bank #(.REVERSED_PORTS(1'b1)) uutRev (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(rd[1]), .pinIn(pinIn), .pinOut(pOut[1]), .pinOe(pOe[1]),
    .pinSel(pSel[1]), .irqOut(irq[1]));

  // behavioural model, index 0 normal order, 1 reversed
  logic [31:0] mSel [2], mDir [2], mOut [2], mSt [2], mS1 [2], mS2 [2], mPrev [2];
  logic [1:0]  mTyp [2][32];

  function automatic logic [31:0] busSwap(logic [31:0] v, int m);
    return (m == 1) ? v : {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic int fieldAt(int l, int m);
    return (m == 1) ? 2 * l : 2 * (8 * ((l / 8) ^ 1) + (l % 8));
  endfunction

  function automatic logic [63:0] maskSpace(int m);
    logic [63:0] s = '0;
    for (int l = 0; l < 32; l++) s[fieldAt(l, m) +: 2] = mTyp[m][l];
    return s;
  endfunction

  function automatic logic [31:0] expRd(int m, logic [4:0] a);
    logic [63:0] s = maskSpace(m);
    case (a[4:2])
      3'd0: return busSwap(mSel[m], m);
      3'd2: return busSwap(mDir[m], m);
      3'd3: return busSwap((mDir[m] & mOut[m]) | (~mDir[m] & mS2[m]), m);
      3'd4: return busSwap(mSt[m], m);
      3'd5: return s[31:0];
      3'd6: return s[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rdTag(int m, logic [4:0] a);
    string b;
    case (a[4:2])
      3'd0, 3'd2: b = "R2";
      3'd3:       b = "R3";
      3'd4:       b = "R4 R5";
      3'd5, 3'd6: b = "R4";
      default:    b = "R11";
    endcase
    return {b, (m == 1) ? " R10" : " R9"};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin : mdl
      logic [31:0] rise, fall, hit, clr;
      if (!rstN) begin
        mSel[m] = '0; mDir[m] = '0; mOut[m] = '0; mSt[m] = '0;
        mS1[m] = '0; mS2[m] = '0; mPrev[m] = '0;
        for (int l = 0; l < 32; l++) mTyp[m][l] = 2'd0;
      end else begin
        rise = mS2[m] & ~mPrev[m];
        fall = ~mS2[m] & mPrev[m];
        for (int l = 0; l < 32; l++)
          hit[l] = !mDir[m][l] && ((mTyp[m][l][1] && rise[l]) || (mTyp[m][l][0] && fall[l]));
        clr = '0;
        if (busWe) begin
          case (busAddr[4:2])
            3'd0: mSel[m] = busSwap(busWdata, m);
            3'd2: mDir[m] = busSwap(busWdata, m);
            3'd3: mOut[m] = busSwap(busWdata, m);
            3'd4: clr = busSwap(busWdata, m);
            3'd5: for (int l = 0; l < 32; l++)
                    if (fieldAt(l, m) < 32) mTyp[m][l] = busWdata[fieldAt(l, m) +: 2];
            3'd6: for (int l = 0; l < 32; l++)
                    if (fieldAt(l, m) >= 32) mTyp[m][l] = busWdata[(fieldAt(l, m) - 32) +: 2];
            default: ;
          endcase
        end
        mSt[m]   = (mSt[m] & ~clr) | hit;
        mPrev[m] = mS2[m];
        mS2[m]   = mS1[m];
        mS1[m]   = pinIn;
      end
    end
  end

  // compare every output shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      for (int m = 0; m < 2; m++) begin
        chk(rdTag(m, busAddr), rd[m], expRd(m, busAddr));
        chk("R2", pOut[m], mOut[m]);
        chk("R2", pOe[m], mDir[m]);
        chk("R2", pSel[m], mSel[m]);
        chk("R8 R12", {31'd0, irq[m]}, {31'd0, mSt[m] != 0});
      end
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(string tag, logic [4:0] a, logic [31:0] e0, logic [31:0] e1);
    busAddr = a;
    #1;
    chk(tag, rd[0], e0);
    chk(tag, rd[1], e1);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) rdChk("R1", 5'(a * 4), 32'h0, 32'h0);
    chk("R1", {31'd0, irq[0]} | {31'd0, irq[1]}, 32'h0);
    chk("R1", pOe[0] | pOe[1] | pOut[0] | pOut[1], 32'h0);

    wr(5'h00, 32'h12345678);
    wr(5'h08, 32'h0000FF00);
    wr(5'h0C, 32'hFFFF00FF);
    wr(5'h14, 32'hFFFFFFFF);
    wr(5'h18, 32'hFFFFFFFF);
    #1;
    chk("R2 R9", pOut[0], 32'hFF00FFFF);
    chk("R2 R10", pOut[1], 32'hFFFF00FF);
    chk("R2 R9", pOe[0], 32'h00FF0000);
    chk("R2 R10", pOe[1], 32'h0000FF00);
    wr(5'h10, 32'hFFFFFFFF);
    idle(4);

    // R12: status and interrupt rise at the third edge
    pinIn[0] = 1'b1;
    @(negedge clk); #1; chk("R12", {31'd0, irq[0]}, 32'h0);
    @(negedge clk); #1; chk("R12", {31'd0, irq[0]}, 32'h0);
    @(negedge clk); #1; chk("R12", {31'd0, irq[0]}, 32'h1);
    chk("R12", {31'd0, irq[1]}, 32'h1);

    // R6: falling edge recorded while the bit is being cleared
    @(negedge clk);
    pinIn[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    busAddr = 5'h10; busWe = 1'b1; busWdata = 32'hFFFFFFFF;
    @(negedge clk);
    busWe = 1'b0;
    rdChk("R6", 5'h10, 32'h01000000, 32'h00000001);
    chk("R6 R8", {31'd0, irq[0]}, 32'h1);

    wr(5'h10, 32'hFFFFFFFF);
    rdChk("R5", 5'h10, 32'h0, 32'h0);
    chk("R8", {31'd0, irq[0]}, 32'h0);

    // R5: writing zero leaves a bit set
    pinIn[1] = 1'b1;
    idle(4);
    wr(5'h10, 32'h00000000);
    rdChk("R5", 5'h10, 32'h02000000, 32'h00000002);
    wr(5'h10, 32'hFFFFFFFF);

    // R7: a line driven as output records nothing
    pinIn[8]  = 1'b1;
    pinIn[16] = 1'b1;
    idle(5);
    rdChk("R7", 5'h10, 32'h00010000, 32'h00010000);

    // R3: data read mixes latch and pins
    rdChk("R3", 5'h0C, 32'h02010000, 32'h00010002);

    // R11: unmapped words
    wr(5'h04, 32'hFFFFFFFF);
    wr(5'h1C, 32'hFFFFFFFF);
    rdChk("R11", 5'h04, 32'h0, 32'h0);
    rdChk("R11", 5'h1C, 32'h0, 32'h0);
    rdChk("R11", 5'h00, 32'h12345678, 32'h12345678);

    // R9 R10: field position 0 belongs to a different line per order
    pinIn = '0;
    wr(5'h14, 32'h00000002);
    wr(5'h18, 32'h00000000);
    idle(4);
    wr(5'h10, 32'hFFFFFFFF);
    rdChk("R4", 5'h14, 32'h00000002, 32'h00000002);
    pinIn[0] = 1'b1;
    pinIn[8] = 1'b1;
    idle(5);
    busAddr = 5'h10;
    #1;
    chk("R9", rd[0], 32'h00010000);
    chk("R10", rd[1], 32'h00000001);

    // mixed traffic, model compared on every edge
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pinIn = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      busAddr = 5'(lfsr[4:2] * 4);
      busWdata = {lfsr[7:0], lfsr[31:8]};
      busWe = (lfsr[12:10] == 3'd0);
    end
    @(negedge clk);
    busWe = 1'b0;
    idle(4);
    finishRun();
  end

endmodule